// File: doc/BRIEF.md
# Instruction Prefix and Operand-Size Decoder

This block sits at the front of an instruction decoder. It takes instruction bytes one per cycle over a valid/ready handshake. It absorbs the legacy prefixes and the register-extension prefix, and stops at the first opcode byte. For that opcode it emits a single decode record. The record holds the opcode byte, the effective operand size and the effective address size, the four extension bits, a stack-class flag and an over-length flag.

Two inputs select how the bytes are read. `mode_long` picks 64-bit long mode. When long mode is off, the block is in compatibility mode, and `seg_def32` gives the code segment's default size. The same byte can be a prefix in one mode and an opcode in the other. The operand size depends on the mode, the prefixes and the opcode class together.

Each record is held at the output until the consumer takes it. While a record waits, no new byte is accepted. After every record the prefix state starts fresh.

Top module: `prefix_size_decoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A byte is taken on a rising edge where `in_valid` and `in_ready` are both 1. The record for an instruction appears with `out_valid`=1 right after the edge that takes its final byte. The record stays unchanged until an edge with `out_ready`=1. While `out_valid` is 1, `in_ready` is 0.
- R3: In long mode, an ordinary opcode (for example 0x03) has operand size 32. With a 0x66 prefix and no REX.W it has operand size 16. Size codes on `out_opsize` and `out_adsize`: 0 means 16, 1 means 32, 2 means 64.
- R4: In long mode, an extension prefix with W=1 gives operand size 64. This holds even when 0x66 is also present.
- R5: These opcodes are stack-class: 0x50–0x5F, 0x68, 0x6A, 0x8F, 0x9C and 0x9D. For them `out_stack` is 1. In long mode they default to size 64, and W=0 leaves that unchanged. A 0x66 prefix without W gives 16. Their size is never 32.
- R6: In long mode, a byte 0x40–0x4F is an extension prefix. Its bit 3 goes to `out_rex_w`, bit 2 to `out_rex_r`, bit 1 to `out_rex_x` and bit 0 to `out_rex_b`. In compatibility mode the same byte is the opcode, and all four bits read 0.
- R7: An extension prefix followed by a legacy prefix is discarded, and its bits read 0. When two extension prefixes arrive back to back, only the later one counts.
- R8: In compatibility mode, the operand size is the segment default (`seg_def32`=1 gives 32, 0 gives 16). A 0x66 prefix flips it to the other size. The size is never 64.
- R9: The address size is 64 in long mode and 32 with 0x67. In compatibility mode it is the segment default, and 0x67 flips it.
- R10: The legacy prefixes are F0, F2, F3, 26, 2E, 36, 3E, 64, 65, 66 and 67. Each is consumed without producing a record. A repeated prefix has the same effect as a single one.
- R11: If byte number MAX_LEN (default 15) of an instruction is still a prefix, a record is emitted with `out_overlong`=1, `out_stack`=0 and that byte as `out_opcode`. Its sizes include that byte's effect. An instruction whose opcode arrives as byte MAX_LEN has `out_overlong`=0.
- R12: After every record, the prefix state is cleared. The next instruction is decoded as if no earlier prefixes had been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_long | input | 1 | 1 = 64-bit long mode, 0 = compatibility mode |
| seg_def32 | input | 1 | Compatibility-mode segment default size, 1 = 32, 0 = 16 |
| in_valid | input | 1 | Instruction byte offered |
| in_ready | output | 1 | Block can take a byte |
| in_byte | input | 8 | Instruction byte |
| out_valid | output | 1 | Decode record present |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 8 | Opcode byte (or last byte of an over-length run) |
| out_opsize | output | 2 | Operand size code: 0=16, 1=32, 2=64 |
| out_adsize | output | 2 | Address size code: 0=16, 1=32, 2=64 |
| out_rex_w | output | 1 | Extension W bit |
| out_rex_r | output | 1 | Extension R bit (4th bit of the ModRM reg index) |
| out_rex_x | output | 1 | Extension X bit (4th bit of the index register) |
| out_rex_b | output | 1 | Extension B bit (4th bit of the base/rm index) |
| out_stack | output | 1 | Opcode is stack-class |
| out_overlong | output | 1 | Instruction exceeded MAX_LEN bytes |

## Verification
A record is due one cycle after the rising edge that takes its final byte. The record then holds until an edge where the consumer is ready, and `in_ready` mirrors it at that same latency. The bench keeps a behavioural model that takes the same bytes at the same edges and computes the expected record from the size rules. On every falling edge it compares `out_valid`, `in_ready` and, when a record is present, every field. Sampling on the falling edge means each comparison sees the state that settled after the edge that produced it.

// File: rtl/psd_pkg.sv
package psd_pkg;

   typedef enum logic [1:0] {
      SZ16 = 2'd0,
      SZ32 = 2'd1,
      SZ64 = 2'd2
   } size_e;

   function automatic logic is_stack_op(input logic [7:0] b);
      return (b[7:4] == 4'h5) || (b == 8'h68) || (b == 8'h6A) ||
             (b == 8'h8F) || (b == 8'h9C) || (b == 8'h9D);
   endfunction

endpackage

// File: rtl/psd_classify.sv
module psd_classify (
   input  logic [7:0] byte_i,
   input  logic       long_i,
   output logic       legacy_o,
   output logic       opsz_o,
   output logic       adsz_o,
   output logic       rex_o
);
   localparam int NLEG = 11;
   localparam logic [7:0] LEG_CODES [NLEG] = '{
      8'hF0, 8'hF2, 8'hF3, 8'h26, 8'h2E, 8'h36,
      8'h3E, 8'h64, 8'h65, 8'h66, 8'h67
   };

   logic [NLEG-1:0] hit;

   for (genvar i = 0; i < NLEG; i++) begin : g_match
      assign hit[i] = (byte_i == LEG_CODES[i]);
   end

   assign legacy_o = |hit;
   assign opsz_o   = (byte_i == 8'h66);
   assign adsz_o   = (byte_i == 8'h67);
   assign rex_o    = long_i && (byte_i[7:4] == 4'h4);

endmodule

// File: rtl/psd_track.sv
module psd_track #(
   parameter int MAX_LEN = 15
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       acc_i,
   input  logic       legacy_i,
   input  logic       opsz_i,
   input  logic       adsz_i,
   input  logic       rex_i,
   input  logic [3:0] low_i,
   output logic       opsz_o,
   output logic       adsz_o,
   output logic [3:0] rex_o,
   output logic       last_o,
   output logic       over_o
);
   localparam int CW = $clog2(MAX_LEN + 1);
   localparam logic [CW-1:0] LAST_IDX = CW'(MAX_LEN - 1);

   logic          opsz_q, adsz_q;
   logic [3:0]    rex_q;
   logic [CW-1:0] cnt_q;
   logic          pfx;
   logic          at_limit;

   assign pfx      = legacy_i || rex_i;
   assign at_limit = (cnt_q == LAST_IDX);

   always_comb begin
      opsz_o = opsz_q || opsz_i;
      adsz_o = adsz_q || adsz_i;
      if (rex_i)         rex_o = low_i;
      else if (legacy_i) rex_o = 4'h0;
      else               rex_o = rex_q;
   end

   assign last_o = !pfx || at_limit;
   assign over_o = pfx && at_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opsz_q <= 1'b0;
         adsz_q <= 1'b0;
         rex_q  <= 4'h0;
         cnt_q  <= '0;
      end else if (acc_i) begin
         if (last_o) begin
            opsz_q <= 1'b0;
            adsz_q <= 1'b0;
            rex_q  <= 4'h0;
            cnt_q  <= '0;
         end else begin
            opsz_q <= opsz_o;
            adsz_q <= adsz_o;
            rex_q  <= rex_o;
            cnt_q  <= cnt_q + 1'b1;
         end
      end
   end

   assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(MAX_LEN));

   assert_rex_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_i && legacy_i |=> rex_q == 4'h0);

endmodule

// File: rtl/psd_size.sv
module psd_size
   import psd_pkg::*;
(
   input  logic  long_i,
   input  logic  seg32_i,
   input  logic  opsz_i,
   input  logic  adsz_i,
   input  logic  w_i,
   input  logic  stack_i,
   output size_e op_o,
   output size_e ad_o
);
   always_comb begin
      if (long_i) begin
         if (w_i)          op_o = SZ64;
         else if (stack_i) op_o = opsz_i ? SZ16 : SZ64;
         else              op_o = opsz_i ? SZ16 : SZ32;
         ad_o = adsz_i ? SZ32 : SZ64;
      end else begin
         op_o = (seg32_i ^ opsz_i) ? SZ32 : SZ16;
         ad_o = (seg32_i ^ adsz_i) ? SZ32 : SZ16;
      end
   end
endmodule

// File: rtl/prefix_size_decoder.sv
module prefix_size_decoder
   import psd_pkg::*;
#(
   parameter int MAX_LEN = 15
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_long,
   input  logic       seg_def32,
   input  logic       in_valid,
   output logic       in_ready,
   input  logic [7:0] in_byte,
   output logic       out_valid,
   input  logic       out_ready,
   output logic [7:0] out_opcode,
   output logic [1:0] out_opsize,
   output logic [1:0] out_adsize,
   output logic       out_rex_w,
   output logic       out_rex_r,
   output logic       out_rex_x,
   output logic       out_rex_b,
   output logic       out_stack,
   output logic       out_overlong
);
   if (MAX_LEN < 2 || MAX_LEN > 255) begin : g_bad_len
      $error("prefix_size_decoder: MAX_LEN must lie in 2..255");
   end

   logic       acc;
   logic       c_legacy, c_opsz, c_adsz, c_rex;
   logic       t_opsz, t_adsz, t_last, t_over;
   logic [3:0] t_rex;
   logic       stk;
   size_e      s_op, s_ad;

   logic       ov_q;
   logic       rec_long_q;
   logic [7:0] opc_q;
   size_e      op_q, ad_q;
   logic [3:0] rex_q;
   logic       stk_q, over_q;

   assign in_ready = !ov_q;
   assign acc      = in_valid && in_ready;

   psd_classify u_cls (
      .byte_i   (in_byte),
      .long_i   (mode_long),
      .legacy_o (c_legacy),
      .opsz_o   (c_opsz),
      .adsz_o   (c_adsz),
      .rex_o    (c_rex)
   );

   psd_track #(.MAX_LEN(MAX_LEN)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_i    (acc),
      .legacy_i (c_legacy),
      .opsz_i   (c_opsz),
      .adsz_i   (c_adsz),
      .rex_i    (c_rex),
      .low_i    (in_byte[3:0]),
      .opsz_o   (t_opsz),
      .adsz_o   (t_adsz),
      .rex_o    (t_rex),
      .last_o   (t_last),
      .over_o   (t_over)
   );

   assign stk = !(c_legacy || c_rex) && is_stack_op(in_byte);

   psd_size u_sz (
      .long_i  (mode_long),
      .seg32_i (seg_def32),
      .opsz_i  (t_opsz),
      .adsz_i  (t_adsz),
      .w_i     (t_rex[3]),
      .stack_i (stk),
      .op_o    (s_op),
      .ad_o    (s_ad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ov_q       <= 1'b0;
         rec_long_q <= 1'b0;
         opc_q      <= 8'h00;
         op_q       <= SZ32;
         ad_q       <= SZ32;
         rex_q      <= 4'h0;
         stk_q      <= 1'b0;
         over_q     <= 1'b0;
      end else if (acc && t_last) begin
         ov_q       <= 1'b1;
         rec_long_q <= mode_long;
         opc_q      <= in_byte;
         op_q       <= s_op;
         ad_q       <= s_ad;
         rex_q      <= t_rex;
         stk_q      <= stk;
         over_q     <= t_over;
      end else if (ov_q && out_ready) begin
         ov_q <= 1'b0;
      end
   end

   assign out_valid    = ov_q;
   assign out_opcode   = opc_q;
   assign out_opsize   = op_q;
   assign out_adsize   = ad_q;
   assign out_rex_w    = rex_q[3];
   assign out_rex_r    = rex_q[2];
   assign out_rex_x    = rex_q[1];
   assign out_rex_b    = rex_q[0];
   assign out_stack    = stk_q;
   assign out_overlong = over_q;

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_opcode) &&
      $stable(out_opsize) && $stable(out_adsize));

   assert_w_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_rex_w |-> out_opsize == SZ64);

   assert_stack_no32_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && rec_long_q && out_stack |-> out_opsize != SZ32);

   assert_compat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !rec_long_q |-> out_opsize != SZ64 &&
      !out_rex_w && !out_rex_r && !out_rex_x && !out_rex_b);

endmodule

// File: tb/prefix_size_decoder_bench.sv
module prefix_size_decoder_bench;
   localparam int CLK_PERIOD = 10;
   localparam int MAXL = 15;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_long = 1'b1;
   logic       seg_def32 = 1'b1;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_byte = 8'h00;
   logic       out_valid;
   logic       out_ready = 1'b1;
   logic [7:0] out_opcode;
   logic [1:0] out_opsize, out_adsize;
   logic       out_rex_w, out_rex_r, out_rex_x, out_rex_b;
   logic       out_stack, out_overlong;

   int total = 0;
   int bad = 0;
   bit done_flag = 0;
   string cur_req = "R1";

   prefix_size_decoder #(.MAX_LEN(MAXL)) u_prefix_size_decoder (
      .clk(clk), .rst_n(rst_n), .mode_long(mode_long), .seg_def32(seg_def32),
      .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
      .out_valid(out_valid), .out_ready(out_ready), .out_opcode(out_opcode),
      .out_opsize(out_opsize), .out_adsize(out_adsize),
      .out_rex_w(out_rex_w), .out_rex_r(out_rex_r), .out_rex_x(out_rex_x),
      .out_rex_b(out_rex_b), .out_stack(out_stack), .out_overlong(out_overlong)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference model
   bit       m_valid = 0;
   int       m_op = 0, m_ad = 0;
   bit [7:0] m_opc = 0;
   bit [3:0] m_rex = 0;
   bit       m_stk = 0, m_over = 0;
   bit       s_o = 0, s_a = 0;
   bit [3:0] s_rex = 0;
   int       s_cnt = 0;

   function automatic bit is_leg(bit [7:0] b);
      bit [7:0] codes [11] = '{8'hF0, 8'hF2, 8'hF3, 8'h26, 8'h2E, 8'h36,
                               8'h3E, 8'h64, 8'h65, 8'h66, 8'h67};
      foreach (codes[i]) if (codes[i] == b) return 1;
      return 0;
   endfunction

   function automatic bit is_stk(bit [7:0] b);
      return (b >= 8'h50 && b <= 8'h5F) || b == 8'h68 || b == 8'h6A ||
             b == 8'h8F || b == 8'h9C || b == 8'h9D;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_valid = 0; s_o = 0; s_a = 0; s_rex = 0; s_cnt = 0;
      end else begin
         bit acc;
         acc = in_valid && !m_valid;
         if (m_valid && out_ready) m_valid = 0;
         if (acc) begin
            bit [7:0] b;
            bit lg, rx, fin;
            b = in_byte;
            lg = is_leg(b);
            rx = mode_long && b[7:4] == 4'h4;
            s_cnt++;
            if (lg) begin
               if (b == 8'h66) s_o = 1;
               if (b == 8'h67) s_a = 1;
               s_rex = 0;
            end else if (rx) begin
               s_rex = b[3:0];
            end
            fin = !(lg || rx) || s_cnt == MAXL;
            if (fin) begin
               m_valid = 1;
               m_opc = b;
               m_rex = s_rex;
               m_stk = !(lg || rx) && is_stk(b);
               m_over = lg || rx;
               if (mode_long) begin
                  if (s_rex[3]) m_op = 2;
                  else if (m_stk) m_op = s_o ? 0 : 2;
                  else m_op = s_o ? 0 : 1;
                  m_ad = s_a ? 1 : 2;
               end else begin
                  m_op = (seg_def32 ^ s_o) ? 1 : 0;
                  m_ad = (seg_def32 ^ s_a) ? 1 : 0;
               end
               s_o = 0; s_a = 0; s_rex = 0; s_cnt = 0;
            end
         end
      end
   end

   task automatic chk(string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", cur_req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         chk("out_valid", out_valid, m_valid);
         chk("in_ready", in_ready, !m_valid);
         if (m_valid && out_valid) begin
            chk("opcode", out_opcode, m_opc);
            chk("opsize", out_opsize, m_op);
            chk("adsize", out_adsize, m_ad);
            chk("rex", {out_rex_w, out_rex_r, out_rex_x, out_rex_b}, m_rex);
            chk("stack", out_stack, m_stk);
            chk("overlong", out_overlong, m_over);
         end
      end
   end

   task automatic send(input bit [7:0] b);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_byte  = b;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      cur_req = "R1";
      chk("reset out_valid", out_valid, 0);
      chk("reset in_ready", in_ready, 1);
      rst_n = 1'b1;

      cur_req = "R3"; mode_long = 1;
      send(8'h03);
      send(8'h66); send(8'h03);

      cur_req = "R4";
      send(8'h48); send(8'h03);
      send(8'h66); send(8'h48); send(8'h03);

      cur_req = "R5";
      send(8'h50);
      send(8'h48); send(8'h5F);
      send(8'h40); send(8'h68);
      send(8'h66); send(8'h8F);
      send(8'h66); send(8'h48); send(8'h9C);
      send(8'h6A);

      cur_req = "R6";
      send(8'h4F); send(8'h03);
      send(8'h45); send(8'h8B);

      cur_req = "R7";
      send(8'h48); send(8'h66); send(8'h03);
      send(8'h41); send(8'h48); send(8'h03);
      send(8'h4C); send(8'h2E); send(8'h50);

      cur_req = "R9";
      send(8'h67); send(8'h8B);
      send(8'h8B);

      cur_req = "R10";
      send(8'hF3); send(8'h2E); send(8'h64); send(8'hF0); send(8'h03);
      send(8'h66); send(8'h66); send(8'h03);
      send(8'hF2); send(8'h26); send(8'h36); send(8'h3E); send(8'h65); send(8'h9D);

      cur_req = "R2";
      send(8'h03);
      out_ready = 1'b0;
      repeat (4) @(negedge clk);
      out_ready = 1'b1;
      send(8'h66);
      send(8'h03);

      cur_req = "R11";
      for (int i = 0; i < MAXL - 1; i++) send(8'h66);
      send(8'h2E);
      for (int i = 0; i < MAXL - 1; i++) send(8'hF3);
      send(8'h03);
      for (int i = 0; i < MAXL - 1; i++) send(8'h67);
      send(8'h48);

      cur_req = "R12";
      send(8'h03);

      cur_req = "R8"; mode_long = 0; seg_def32 = 1;
      send(8'h03);
      send(8'h66); send(8'h03);
      send(8'h48);
      send(8'h66); send(8'h50);
      seg_def32 = 0;
      send(8'h03);
      send(8'h66); send(8'h03);
      cur_req = "R6";
      send(8'h40);
      send(8'h4F);
      cur_req = "R9";
      send(8'h67); send(8'h8B);
      seg_def32 = 1;
      send(8'h67); send(8'h8B);

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule